// File: doc/BRIEF.md
# Five-Class Fixed-Priority Memory Port Arbiter

This block sits between a core with separate instruction and data paths and a single shared memory or peripheral port. Five request classes compete for that port: data write, program write, data read, program read and instruction fetch. In every cycle the arbiter picks at most one class and steers that class's address, write data and write strobe onto the port. Every other active requester sees its stall line held high for that cycle.

The program side uses 22-bit addresses, and the data read and data write sides use 32-bit addresses. All paths carry 32-bit data, so a full word moves in a single cycle. The port expects a synchronous memory. Read data comes back one cycle after the read is granted and is presented with a valid flag and a code naming the class it belongs to.

The architecture never raises two particular pairs of requests together: the two write classes, and program read with instruction fetch. The arbiter watches for a breach of this and flags it, but it does not change how the grant is decided.

Top module: `mem_arb_top`

## Requirements
- R1: While reset is held, and on the first idle cycle after it, `rd_valid` is 0, `grant` is 0 and `rd_data` is 0.
- R2: The grant goes to exactly one active class, chosen by this fixed order from highest to lowest: data write, program write, data read, program read, fetch. `grant` bit 0 stands for data write, bit 1 for program write, bit 2 for data read, bit 3 for program read and bit 4 for fetch.
- R3: A class's stall output is high exactly when its request is high and that class is not granted in the same cycle.
- R4: When a program-side class is granted, `mem_addr` carries its 22-bit address in bits 21:0, with bits 31:22 at zero.
- R5: `mem_we` is high only while a write class is granted. `mem_wdata` then equals that class's write data, and it is zero in every other cycle.
- R6: `mem_re` is high exactly when a read class is granted (data read, program read or fetch).
- R7: In the cycle after a read grant, `rd_valid` is 1 and `rd_data` equals `mem_rdata`. `rd_class` carries the class code: 2 for data read, 3 for program read, 4 for fetch. A write grant leaves `rd_valid` at 0 in the following cycle.
- R8: `excl_err` is high in any cycle where both write classes are requested, or where program read and fetch are both requested. The grant in such a cycle still follows R2.
- R9: With no request active, `grant`, `mem_we` and `mem_re` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dw_req | input | 1 | Data write request |
| dw_addr | input | 32 | Data write address |
| dw_wdata | input | 32 | Data write data |
| dw_stall | output | 1 | Data write stalled |
| pw_req | input | 1 | Program write request |
| pw_addr | input | 22 | Program write address |
| pw_wdata | input | 32 | Program write data |
| pw_stall | output | 1 | Program write stalled |
| dr_req | input | 1 | Data read request |
| dr_addr | input | 32 | Data read address |
| dr_stall | output | 1 | Data read stalled |
| pr_req | input | 1 | Program read request |
| pr_addr | input | 22 | Program read address |
| pr_stall | output | 1 | Program read stalled |
| if_req | input | 1 | Instruction fetch request |
| if_addr | input | 22 | Fetch address |
| if_stall | output | 1 | Fetch stalled |
| mem_addr | output | 32 | Address to the memory port |
| mem_wdata | output | 32 | Write data to the memory port |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | 32 | Read data from the memory, one cycle after the read strobe |
| grant | output | 5 | One-hot grant, indexed by class |
| rd_valid | output | 1 | Returned read data is valid |
| rd_data | output | 32 | Returned read data |
| rd_class | output | 3 | Class code of the returned data |
| excl_err | output | 1 | Exclusive-pair violation |

## Verification
Single requests from each class show that every class reaches the port, that program addresses are zero-extended, and that each class has its own write and read strobes. Pairs and full sets of requests, including the all-five pattern and each request paired with a lower neighbour, pin down every step of the priority order and the matching stall lines. Read grants followed by an idle cycle, with the memory model returning data that depends on the address, separate data that belongs to the right class from stale or misrouted data. Patterns that break each exclusive pair, set next to legal patterns, show that the error flag fires only on the pairs and leaves the grant unchanged.

// File: rtl/mem_arb_pkg.sv
package mem_arb_pkg;
  localparam int unsigned NCLS  = 5;
  localparam int unsigned AW    = 32;
  localparam int unsigned PAW   = 22;
  localparam int unsigned DW    = 32;
  localparam int unsigned CLSW  = $clog2(NCLS);

  typedef enum logic [CLSW-1:0] {
    CLS_DWR = 3'd0,
    CLS_PWR = 3'd1,
    CLS_DRD = 3'd2,
    CLS_PRD = 3'd3,
    CLS_FET = 3'd4
  } cls_e;

  localparam logic [NCLS-1:0] WR_MASK = 5'b00011;
  localparam logic [NCLS-1:0] RD_MASK = 5'b11100;
endpackage

// File: rtl/mem_arb_prio.sv
module mem_arb_prio #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [N:0] above;
  assign above[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_lvl
    assign above[i+1] = above[i] | req[i];
    assign gnt[i]     = req[i] & ~above[i];
  end
endmodule

// File: rtl/mem_arb_route.sv
module mem_arb_route #(
  parameter int unsigned N  = 5,
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter logic [N-1:0] WMASK = '0,
  parameter logic [N-1:0] RMASK = '0
) (
  input  logic [N-1:0]         gnt,
  input  logic [N-1:0][AW-1:0] addr,
  input  logic [N-1:0][DW-1:0] wdata,
  output logic [AW-1:0]        mem_addr,
  output logic [DW-1:0]        mem_wdata,
  output logic                 mem_we,
  output logic                 mem_re
);
  logic [N:0][AW-1:0] a_acc;
  logic [N:0][DW-1:0] d_acc;
  assign a_acc[0] = '0;
  assign d_acc[0] = '0;
  for (genvar i = 0; i < N; i++) begin : g_mux
    assign a_acc[i+1] = a_acc[i] | (addr[i] & {AW{gnt[i]}});
    if (WMASK[i]) begin : g_wr
      assign d_acc[i+1] = d_acc[i] | (wdata[i] & {DW{gnt[i]}});
    end else begin : g_nowr
      assign d_acc[i+1] = d_acc[i];
    end
  end
  assign mem_addr  = a_acc[N];
  assign mem_wdata = d_acc[N];
  assign mem_we    = |(gnt & WMASK);
  assign mem_re    = |(gnt & RMASK);
endmodule

// File: rtl/mem_arb_rdret.sv
module mem_arb_rdret
  import mem_arb_pkg::*;
#(
  parameter int unsigned N  = NCLS,
  parameter int unsigned DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    gnt,
  input  logic [DW-1:0]   mem_rdata,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  output logic [CLSW-1:0] rd_class
);
  logic            vld_q, vld_d;
  logic [CLSW-1:0] cls_q, cls_d;
  logic            cls_en;

  always_comb begin
    vld_d = |(gnt & RD_MASK);
    cls_d = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt[i]) cls_d = CLSW'(i);
    end
  end
  assign cls_en = vld_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      cls_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (cls_en) cls_q <= cls_d;
    end
  end

  assign rd_valid = vld_q;
  assign rd_class = vld_q ? cls_q : '0;
  assign rd_data  = vld_q ? mem_rdata : '0;
endmodule

// File: rtl/mem_arb_top.sv
module mem_arb_top
  import mem_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dw_req,
  input  logic [AW-1:0]    dw_addr,
  input  logic [DW-1:0]    dw_wdata,
  output logic             dw_stall,
  input  logic             pw_req,
  input  logic [PAW-1:0]   pw_addr,
  input  logic [DW-1:0]    pw_wdata,
  output logic             pw_stall,
  input  logic             dr_req,
  input  logic [AW-1:0]    dr_addr,
  output logic             dr_stall,
  input  logic             pr_req,
  input  logic [PAW-1:0]   pr_addr,
  output logic             pr_stall,
  input  logic             if_req,
  input  logic [PAW-1:0]   if_addr,
  output logic             if_stall,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             mem_we,
  output logic             mem_re,
  input  logic [DW-1:0]    mem_rdata,
  output logic [NCLS-1:0]  grant,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  output logic [CLSW-1:0]  rd_class,
  output logic             excl_err
);
  logic [NCLS-1:0]         req, stall;
  logic [NCLS-1:0][AW-1:0] addr;
  logic [NCLS-1:0][DW-1:0] wdata;

  assign req = {if_req, pr_req, dr_req, pw_req, dw_req};

  assign addr[CLS_DWR] = dw_addr;
  assign addr[CLS_PWR] = {{(AW-PAW){1'b0}}, pw_addr};
  assign addr[CLS_DRD] = dr_addr;
  assign addr[CLS_PRD] = {{(AW-PAW){1'b0}}, pr_addr};
  assign addr[CLS_FET] = {{(AW-PAW){1'b0}}, if_addr};

  assign wdata[CLS_DWR] = dw_wdata;
  assign wdata[CLS_PWR] = pw_wdata;
  assign wdata[CLS_DRD] = '0;
  assign wdata[CLS_PRD] = '0;
  assign wdata[CLS_FET] = '0;

  mem_arb_prio #(.N(NCLS)) u_prio (.req(req), .gnt(grant));

  mem_arb_route #(
    .N(NCLS), .AW(AW), .DW(DW), .WMASK(WR_MASK), .RMASK(RD_MASK)
  ) u_route (
    .gnt(grant), .addr(addr), .wdata(wdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re)
  );

  mem_arb_rdret #(.N(NCLS), .DW(DW)) u_rdret (
    .clk(clk), .rst_n(rst_n), .gnt(grant), .mem_rdata(mem_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_class(rd_class)
  );

  assign stall    = req & ~grant;
  assign dw_stall = stall[CLS_DWR];
  assign pw_stall = stall[CLS_PWR];
  assign dr_stall = stall[CLS_DRD];
  assign pr_stall = stall[CLS_PRD];
  assign if_stall = stall[CLS_FET];

  assign excl_err = (dw_req & pw_req) | (pr_req & if_req);
endmodule

// File: rtl/mem_arb_chk.sv
module mem_arb_chk
  import mem_arb_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            dw_req, pw_req, dr_req, pr_req, if_req,
  input logic            dw_stall, dr_stall, if_stall,
  input logic [NCLS-1:0] grant,
  input logic            mem_we,
  input logic            mem_re,
  input logic            rd_valid,
  input logic [CLSW-1:0] rd_class,
  input logic            excl_err
);
  logic [NCLS-1:0] req;
  assign req = {if_req, pr_req, dr_req, pw_req, dw_req};

  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_grant_has_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);
  assert_busy_grants_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> $countones(grant) == 1);
  assert_dw_never_stalls_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dw_stall);
  assert_fetch_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (if_req && (dw_req || pw_req || dr_req || pr_req)) |-> if_stall);
  assert_dr_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dr_stall |-> (dw_req || pw_req));
  assert_we_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (grant[CLS_DWR] || grant[CLS_PWR]));
  assert_re_excl_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  assert_read_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (rd_valid && rd_class >= CLSW'(CLS_DRD)));
  assert_write_no_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !rd_valid);
  assert_err_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    excl_err |-> $onehot(grant));
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> (!mem_we && !mem_re && grant == '0));
endmodule

bind mem_arb_top mem_arb_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .dw_req(dw_req), .pw_req(pw_req), .dr_req(dr_req), .pr_req(pr_req), .if_req(if_req),
  .dw_stall(dw_stall), .dr_stall(dr_stall), .if_stall(if_stall),
  .grant(grant), .mem_we(mem_we), .mem_re(mem_re),
  .rd_valid(rd_valid), .rd_class(rd_class), .excl_err(excl_err)
);

// File: tb/mem_arb_top_tb_top.sv
module mem_arb_top_tb_top;
  localparam logic [31:0] KEY = 32'h5A5A_0F0F;

  logic clk, rst_n;
  logic dw_req, pw_req, dr_req, pr_req, if_req;
  logic [31:0] dw_addr, dw_wdata, pw_wdata, dr_addr;
  logic [21:0] pw_addr, pr_addr, if_addr;
  logic dw_stall, pw_stall, dr_stall, pr_stall, if_stall;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rd_data;
  logic mem_we, mem_re, rd_valid, excl_err;
  logic [4:0] grant;
  logic [2:0] rd_class;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  mem_arb_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .dw_req(dw_req), .dw_addr(dw_addr), .dw_wdata(dw_wdata), .dw_stall(dw_stall),
    .pw_req(pw_req), .pw_addr(pw_addr), .pw_wdata(pw_wdata), .pw_stall(pw_stall),
    .dr_req(dr_req), .dr_addr(dr_addr), .dr_stall(dr_stall),
    .pr_req(pr_req), .pr_addr(pr_addr), .pr_stall(pr_stall),
    .if_req(if_req), .if_addr(if_addr), .if_stall(if_stall),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .grant(grant), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_class(rd_class), .excl_err(excl_err)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  always @(posedge clk) mem_rdata <= mem_re ? (mem_addr ^ KEY) : 32'h0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] r);
    {if_req, pr_req, dr_req, pw_req, dw_req} = r;
  endtask

  function automatic logic [4:0] ref_grant(input logic [4:0] r);
    for (int i = 0; i < 5; i++) if (r[i]) return 5'(1 << i);
    return 5'b0;
  endfunction

  task automatic step_idle();
    @(negedge clk); drive(5'b0); #1;
  endtask

  task automatic t_reset();
    rst_n = 0; drive(5'b0);
    dw_addr = 32'h1000_0010; dw_wdata = 32'hDEAD_0001;
    pw_addr = 22'h2A_5555;   pw_wdata = 32'hBEEF_0002;
    dr_addr = 32'h8000_0300; pr_addr = 22'h3F_FFFF; if_addr = 22'h01_2345;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 rd_valid in reset", {31'b0, rd_valid}, 0);
    chk("R1 grant in reset", {27'b0, grant}, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk); #1;
    chk("R1 rd_valid after reset", {31'b0, rd_valid}, 0);
    chk("R1 rd_data after reset", rd_data, 0);
  endtask

  task automatic t_priority();
    logic [4:0] pats [8] = '{5'b11111, 5'b11100, 5'b11000, 5'b10100,
                             5'b01010, 5'b00110, 5'b10001, 5'b10000};
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); drive(pats[k]); #1;
      chk($sformatf("R2 grant pat %b", pats[k]), {27'b0, grant}, {27'b0, ref_grant(pats[k])});
      chk($sformatf("R3 stalls pat %b", pats[k]),
          {27'b0, if_stall, pr_stall, dr_stall, pw_stall, dw_stall},
          {27'b0, pats[k] & ~ref_grant(pats[k])});
    end
    step_idle();
  endtask

  task automatic t_zext();
    @(negedge clk); drive(5'b00010); #1;
    chk("R4 pw zext addr", mem_addr, {10'b0, pw_addr});
    @(negedge clk); drive(5'b01000); #1;
    chk("R4 pr zext addr", mem_addr, {10'b0, pr_addr});
    @(negedge clk); drive(5'b10000); #1;
    chk("R4 if zext addr", mem_addr, {10'b0, if_addr});
    step_idle();
  endtask

  task automatic t_write();
    @(negedge clk); drive(5'b00101); #1;
    chk("R5 dw we", {31'b0, mem_we}, 1);
    chk("R5 dw wdata", mem_wdata, dw_wdata);
    chk("R5 dw addr", mem_addr, dw_addr);
    chk("R6 re low on write", {31'b0, mem_re}, 0);
    @(negedge clk); drive(5'b00010); #1;
    chk("R5 pw wdata", mem_wdata, pw_wdata);
    @(negedge clk); drive(5'b0); #1;
    chk("R7 no rd_valid after write", {31'b0, rd_valid}, 0);
    @(negedge clk); drive(5'b00100); #1;
    chk("R5 we low on read", {31'b0, mem_we}, 0);
    chk("R5 wdata zero on read", mem_wdata, 0);
    chk("R6 re on data read", {31'b0, mem_re}, 1);
    step_idle();
  endtask

  task automatic t_readret();
    logic [4:0]  reqs [3] = '{5'b00100, 5'b01000, 5'b10000};
    logic [2:0]  cls  [3] = '{3'd2, 3'd3, 3'd4};
    logic [31:0] adr;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); drive(reqs[k]); #1;
      adr = mem_addr;
      chk("R6 re on read class", {31'b0, mem_re}, 1);
      @(negedge clk); drive(5'b0); #1;
      chk("R7 rd_valid", {31'b0, rd_valid}, 1);
      chk("R7 rd_class", {29'b0, rd_class}, {29'b0, cls[k]});
      chk("R7 rd_data", rd_data, adr ^ KEY);
    end
    @(negedge clk); drive(5'b10000);
    @(negedge clk); drive(5'b00100); #1;
    chk("R7 back-to-back first", {29'b0, rd_class}, 4);
    @(negedge clk); drive(5'b0); #1;
    chk("R7 back-to-back second", {29'b0, rd_class}, 2);
    chk("R7 back-to-back data", rd_data, dr_addr ^ KEY);
    step_idle();
  endtask

  task automatic t_excl();
    @(negedge clk); drive(5'b00011); #1;
    chk("R8 err writes", {31'b0, excl_err}, 1);
    chk("R8 grant writes", {27'b0, grant}, 5'b00001);
    @(negedge clk); drive(5'b11000); #1;
    chk("R8 err pr+if", {31'b0, excl_err}, 1);
    chk("R8 grant pr+if", {27'b0, grant}, 5'b01000);
    @(negedge clk); drive(5'b10101); #1;
    chk("R8 no err legal mix", {31'b0, excl_err}, 0);
    @(negedge clk); drive(5'b01001); #1;
    chk("R8 no err dw+pr", {31'b0, excl_err}, 0);
    step_idle();
  endtask

  task automatic t_idle();
    step_idle();
    chk("R9 idle grant", {27'b0, grant}, 0);
    chk("R9 idle we", {31'b0, mem_we}, 0);
    chk("R9 idle re", {31'b0, mem_re}, 0);
  endtask

  initial begin
    t_reset();
    t_priority();
    t_zext();
    t_write();
    t_readret();
    t_excl();
    t_idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule